// File: doc/BRIEF.md
# Truth-Table Bitwise Logic Unit

This block computes a bitwise logic function of two operand words, `opa` and `opb`. A 4-bit function code `func` selects the operation. Each result bit comes from its own 4-to-1 multiplexer. The multiplexer data inputs are the four code bits, and its select lines are the two operand bits at that position. The code is therefore the truth table of the operation, and any of the sixteen two-input boolean functions can be chosen without changing the hardware. A datapath uses it by placing the code for the wanted operation on `func`. The codes for AND, OR, XOR and copy-of-A are listed below.

The multiplexer array is purely combinational. Its output is captured in a register, so a result appears one clock after its operands and code are sampled. Reset clears the register to zero. Turning instruction opcodes into function codes is done outside this block.

Top module: `truthtab_logic_unit`

## Requirements
- R1: The result is registered. Inputs sampled at one rising clock edge appear on `result` from that edge until the next one, which is a latency of one cycle.
- R2: While `rst_n` is low, `result` is all zeros, whatever the inputs are.
- R3: For every bit position i, result bit i equals `func[{opb[i], opa[i]}]`. The select index is `opb[i]` as the high bit and `opa[i]` as the low bit. So `func[0]` is chosen when both bits are 0, `func[1]` when only `opa[i]` is 1, `func[2]` when only `opb[i]` is 1, and `func[3]` when both are 1.
- R4: Code 4'b1000 gives the bitwise AND of `opa` and `opb`.
- R5: Code 4'b1110 gives the bitwise OR of `opa` and `opb`.
- R6: Code 4'b0110 gives the bitwise XOR of `opa` and `opb`.
- R7: Code 4'b1010 passes `opa` through unchanged, and `opb` has no effect on the result.
- R8: Code 4'b0000 gives all zeros and code 4'b1111 gives all ones, whatever the operands are.
- R9: Each result bit depends only on the operand bits at its own position. A single set operand bit affects only that bit of the result.
- R10: If the operands and code are held for consecutive cycles, `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears the result register |
| opa | input | WIDTH (32) | First operand; low bit of each per-bit select |
| opb | input | WIDTH (32) | Second operand; high bit of each per-bit select |
| func | input | 4 | Function code; truth table of the operation |
| result | output | WIDTH (32) | Registered bitwise result |

## Verification
Every cycle, the assertions compare the result against a sum-of-minterms model built from the previous cycle's operands and code. They also check that the zero and ones codes give constant words, that the output is zero in the first cycle after reset, and that steady inputs give a steady output. Some behaviour can only be shown by the bench's scenarios. These are the named operation codes checked against their plain operator meaning, the sweep over all sixteen codes, walking-one isolation between bit positions, and the result being held low while reset is applied with busy inputs.

// File: rtl/lgu_pkg.sv
package lgu_pkg;
    localparam int CODE_W   = 4;
    localparam int SEL_W    = 2;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_ZERO = 4'b0000;
    localparam code_t CODE_AND  = 4'b1000;
    localparam code_t CODE_OR   = 4'b1110;
    localparam code_t CODE_XOR  = 4'b0110;
    localparam code_t CODE_PASSA = 4'b1010;
    localparam code_t CODE_ONES = 4'b1111;
endpackage

// File: rtl/lgu_bit_mux.sv
module lgu_bit_mux
    import lgu_pkg::*;
(
    input  code_t code,
    input  logic  sel_lo,
    input  logic  sel_hi,
    output logic  y
);
    logic pick_low_pair;
    logic pick_high_pair;

    always_comb begin
        pick_low_pair  = sel_lo ? code[1] : code[0];
        pick_high_pair = sel_lo ? code[3] : code[2];
        y              = sel_hi ? pick_high_pair : pick_low_pair;
    end
endmodule

// File: rtl/lgu_mux_array.sv
module lgu_mux_array
    import lgu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  code_t             code,
    input  logic [WIDTH-1:0]  word_a,
    input  logic [WIDTH-1:0]  word_b,
    output logic [WIDTH-1:0]  word_y
);
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        lgu_bit_mux u_mux (
            .code   (code),
            .sel_lo (word_a[gi]),
            .sel_hi (word_b[gi]),
            .y      (word_y[gi])
        );
    end
endmodule

// File: rtl/truthtab_logic_unit.sv
module truthtab_logic_unit
    import lgu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [3:0]       func,
    output logic [WIDTH-1:0] result
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    logic [WIDTH-1:0] mux_word;

    lgu_mux_array #(.WIDTH(WIDTH)) u_array (
        .code   (code_t'(func)),
        .word_a (opa),
        .word_b (opb),
        .word_y (mux_word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.res = mux_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.res;
endmodule

// File: rtl/lgu_checker.sv
module lgu_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [3:0]       func,
    input logic [WIDTH-1:0] result
);
    logic live_q;
    logic after_rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q      <= 1'b0;
            after_rst_q <= 1'b1;
        end else begin
            live_q      <= 1'b1;
            after_rst_q <= 1'b0;
        end
    end

    function automatic logic [WIDTH-1:0] minterm_model(
        input logic [WIDTH-1:0] a,
        input logic [WIDTH-1:0] b,
        input logic [3:0]       c
    );
        minterm_model = ({WIDTH{c[0]}} & ~a & ~b)
                      | ({WIDTH{c[1]}} &  a & ~b)
                      | ({WIDTH{c[2]}} & ~a &  b)
                      | ({WIDTH{c[3]}} &  a &  b);
    endfunction

    AST_TRUTH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (result == minterm_model($past(opa), $past(opb), $past(func)))); // R3

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        after_rst_q |-> (result == '0)); // R2

    AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(func) == 4'b0000) |-> (result == '0)); // R8

    AST_ONES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(func) == 4'b1111) |-> (result == '1)); // R8

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $stable(opa) && $stable(opb) && $stable(func)) |=> $stable(result)); // R10
endmodule

bind truthtab_logic_unit lgu_checker #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .opa    (opa),
    .opb    (opb),
    .func   (func),
    .result (result)
);

// File: tb/truthtab_logic_unit_tb.sv
module truthtab_logic_unit_tb;
    localparam int  WIDTH  = 32;
    localparam time CLK_PD = 10ns;

    typedef struct {
        logic [WIDTH-1:0] exp;
        int               due;
        string            req;
    } item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] opa = '0;
    logic [WIDTH-1:0] opb = '0;
    logic [3:0]       func = '0;
    logic [WIDTH-1:0] result;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    item_t sb[$];

    truthtab_logic_unit #(.WIDTH(WIDTH)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .opa    (opa),
        .opb    (opb),
        .func   (func),
        .result (result)
    );

    always #(CLK_PD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [WIDTH-1:0] by_table(
        input logic [WIDTH-1:0] a,
        input logic [WIDTH-1:0] b,
        input logic [3:0]       c
    );
        logic [WIDTH-1:0] r;
        for (int i = 0; i < WIDTH; i++) r[i] = c[{b[i], a[i]}];
        return r;
    endfunction

    task automatic report(input string req, input logic [WIDTH-1:0] act,
                          input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                         input logic [3:0] c, input logic [WIDTH-1:0] exp,
                         input string req);
        item_t it;
        @(posedge clk);
        #1;
        opa  = a;
        opb  = b;
        func = c;
        it.exp = exp;
        it.due = cyc + 1;
        it.req = req;
        sb.push_back(it);
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            report(it.req, result, it.exp);
        end
    end

    initial begin
        #(CLK_PD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [WIDTH-1:0] pa;
        logic [WIDTH-1:0] pb;
        // R2: reset holds result low with busy inputs
        opa = 32'hFFFF_FFFF;
        opb = 32'hA5A5_A5A5;
        func = 4'b1111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        report("R2 reset", result, '0);
        #1 rst_n = 1'b1;

        pa = 32'hF0F0_3C3C;
        pb = 32'hFF00_5A5A;
        // R4 AND, R5 OR, R6 XOR, R7 pass A
        drive(pa, pb, 4'b1000, pa & pb, "R4 and");
        drive(pa, pb, 4'b1110, pa | pb, "R5 or");
        drive(pa, pb, 4'b0110, pa ^ pb, "R6 xor");
        drive(pa, pb, 4'b1010, pa, "R7 passA");
        drive(pa, ~pb, 4'b1010, pa, "R7 passA opb ignored");
        drive(32'h1234_5678, 32'h8765_4321, 4'b1000, 32'h1234_5678 & 32'h8765_4321, "R4 and");
        drive(32'h0000_0000, 32'hFFFF_FFFF, 4'b0110, 32'hFFFF_FFFF, "R6 xor");
        // R8: constant codes
        drive(pa, pb, 4'b0000, '0, "R8 zero");
        drive(pa, pb, 4'b1111, '1, "R8 ones");
        // R3: sweep all codes over a pattern holding every (b,a) pair
        for (int c = 0; c < 16; c++) begin
            drive(32'hCCCC_CCCC, 32'hF0F0_F0F0, 4'(c),
                  by_table(32'hCCCC_CCCC, 32'hF0F0_F0F0, 4'(c)), "R3 sweep");
        end
        for (int c = 0; c < 16; c++) begin
            drive(32'h9E37_79B9 ^ (c * 32'h0101_0101), 32'h7F4A_7C15, 4'(c),
                  by_table(32'h9E37_79B9 ^ (c * 32'h0101_0101), 32'h7F4A_7C15, 4'(c)),
                  "R3 mixed");
        end
        // R9: walking one stays in its own position
        for (int i = 0; i < WIDTH; i += 5) begin
            drive(32'(1) << i, '0, 4'b0110, 32'(1) << i, "R9 walk");
        end
        // R1 and R10: back-to-back and held inputs
        drive(32'hAAAA_5555, 32'h0F0F_0F0F, 4'b1110, 32'hAAAA_5555 | 32'h0F0F_0F0F, "R1 latency");
        drive(32'hAAAA_5555, 32'h0F0F_0F0F, 4'b1110, 32'hAAAA_5555 | 32'h0F0F_0F0F, "R10 hold");
        drive(32'hAAAA_5555, 32'h0F0F_0F0F, 4'b1110, 32'hAAAA_5555 | 32'h0F0F_0F0F, "R10 hold");
        drive(32'h0000_0001, 32'h0000_0001, 4'b1000, 32'h0000_0001, "R1 next");
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R1 pending actual=%0d expected=0", sb.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule